// File: doc/BRIEF.md
# Serial Flash Sector Lock Controller

This block sits behind the serial command port of a flash device and keeps a volatile two-bit lock state for every sector. It receives SPI mode 0 frames on one data line and decodes two commands. One arms a write-enable latch. The other writes one sector's lock byte, and the address bits of the frame select that sector. The lock state then decides whether program and erase requests from the device's internal engines are granted or blocked for that sector.

A sector's write-lock bit can be set or cleared freely until its lock-down bit is set. From then on, both bits of that sector stay frozen until reset. A lock write only takes effect when chip select rises directly after the last data bit, the write-enable latch is set, and no program or erase cycle is in progress. The serial pins are oversampled in the system clock domain.

Top module: `sector_lock_ctrl`

## Requirements
- R1: Each sector's lock byte uses bit 0 as write-lock and bit 1 as lock-down. Bits 7 to 2 of a written byte have no effect.
- R2: A program or erase request (`pe_req`) for a sector whose write-lock is 1 yields `pe_block`=1 and `pe_grant`=0 one clock later. For a sector whose write-lock is 0, it yields `pe_grant`=1 and `pe_block`=0.
- R3: Once a sector's lock-down bit is 1, neither of its lock bits changes until reset.
- R4: While a sector's lock-down bit is 0, an accepted lock write loads both bits from the data byte, including clearing them.
- R5: Opcode 0x06 sent as an 8-bit frame sets the write-enable latch (`wel_o`=1). A lock write (opcode 0xE5) with the latch clear changes nothing.
- R6: A lock frame is sent MSB first and consists of the 8-bit opcode 0xE5, then a 24-bit address, then one data byte. Address bits 23..16 select the sector, and the lower address bits are ignored.
- R7: A lock write commits only if chip select rises after exactly 40 bits. Write enable commits only after exactly 8 bits. Any other bit count discards the frame, and the bit count restarts at every chip select rise.
- R8: An executed lock write clears the write-enable latch, even when lock-down keeps the bits from changing.
- R9: A lock write that completes while `busy_i` is 1 is rejected. The lock bits and the write-enable latch stay as they were.
- R10: Frames carrying any other opcode change neither the lock bits nor the latch.
- R11: After reset, every sector is unlocked and not locked down, and `wel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data input |
| busy_i | input | 1 | Program/erase/write cycle in progress |
| pe_req | input | 1 | Program or erase request from an internal engine |
| pe_sector | input | 8 | Sector targeted by the request |
| pe_grant | output | 1 | Request may proceed (registered) |
| pe_block | output | 1 | Request suppressed by write-lock (registered) |
| wel_o | output | 1 | Write-enable latch state |

## Verification
A seeded random mix of write-enable frames, complete lock frames, truncated and over-long frames, foreign opcodes and busy windows runs against a bench model. After every frame the bench probes the touched sector and a random sector through the request path. Targeted sequences separate the individual rules. Lock-down followed by a clear attempt shows stickiness. A lock write without write enable shows the latch gate. Frames of 39 and 41 bits show the exact-count rule. A busy-time frame shows rejection with the latch kept. A byte with only reserved bits set shows that those bits are ignored.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;
  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_WR_LOCK   = 8'hE5;
  localparam int FRAME_BITS  = 40;
  localparam int ENABLE_BITS = 8;
  localparam int BIT_WL = 0;
  localparam int BIT_LD = 1;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic csn_in,
  input  logic mosi_in,
  output logic sck_rise,
  output logic cs_rise,
  output logic cs_active,
  output logic data_bit
);
  logic [2:0] sck_q;
  logic [2:0] csn_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_in};
      csn_q  <= {csn_q[1:0], csn_in};
      mosi_q <= {mosi_q[0], mosi_in};
    end
  end

  assign sck_rise  = sck_q[1] & ~sck_q[2];
  assign cs_rise   = csn_q[1] & ~csn_q[2];
  assign cs_active = ~csn_q[1];
  assign data_bit  = mosi_q[1];
endmodule

// File: rtl/lock_cmd_decoder.sv
module lock_cmd_decoder #(
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_rise,
  input  logic             cs_rise,
  input  logic             cs_active,
  input  logic             data_bit,
  output logic             wren_pulse,
  output logic             wrlr_pulse,
  output logic [SEC_W-1:0] wrlr_sector,
  output logic [7:0]       wrlr_data
);
  import sector_lock_pkg::*;
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      bit_cnt     <= '0;
      wren_pulse  <= 1'b0;
      wrlr_pulse  <= 1'b0;
      wrlr_sector <= '0;
      wrlr_data   <= '0;
    end else begin
      wren_pulse <= 1'b0;
      wrlr_pulse <= 1'b0;
      if (cs_rise) begin
        bit_cnt <= '0;
        if (bit_cnt == CNT_W'(ENABLE_BITS) && shreg[7:0] == OP_WR_ENABLE)
          wren_pulse <= 1'b1;
        if (bit_cnt == CNT_W'(FRAME_BITS) &&
            shreg[FRAME_BITS-1 -: 8] == OP_WR_LOCK) begin
          wrlr_pulse  <= 1'b1;
          wrlr_sector <= shreg[FRAME_BITS-9 -: SEC_W];
          wrlr_data   <= shreg[7:0];
        end
      end else if (!cs_active) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], data_bit};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R7: a frame only yields a command on a chip-select rise
  p_cmd_on_csrise_r7: assert property (@(posedge clk) disable iff (rst)
    (wren_pulse || wrlr_pulse) |-> $past(cs_rise));
  // R7: counter restarts after chip select rises
  p_cnt_restart_r7: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> bit_cnt == '0);
endmodule

// File: rtl/lock_reg_file.sv
module lock_reg_file #(
  parameter int NUM_SECTORS = 256,
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [SEC_W-1:0] upd_sector,
  input  logic [7:0]       upd_data,
  input  logic             pe_req,
  input  logic [SEC_W-1:0] pe_sector,
  output logic             pe_grant,
  output logic             pe_block
);
  import sector_lock_pkg::*;
  logic [NUM_SECTORS-1:0] wl_q;
  logic [NUM_SECTORS-1:0] ld_q;
  logic                   pe_locked;

  assign pe_locked = wl_q[pe_sector];

  always_ff @(posedge clk) begin
    if (rst) begin
      wl_q     <= '0;
      ld_q     <= '0;
      pe_grant <= 1'b0;
      pe_block <= 1'b0;
    end else begin
      if (upd_en && !ld_q[upd_sector]) begin
        wl_q[upd_sector] <= upd_data[BIT_WL];
        ld_q[upd_sector] <= upd_data[BIT_LD];
      end
      pe_grant <= pe_req & ~pe_locked;
      pe_block <= pe_req & pe_locked;
    end
  end

  // R2: a locked sector never gets a grant
  p_block_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (pe_req && wl_q[pe_sector]) |=> (pe_block && !pe_grant));
  // R4: unfrozen sector takes the written bits
  p_load_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !ld_q[upd_sector]) |=>
      (wl_q[$past(upd_sector)] == $past(upd_data[BIT_WL])) &&
      (ld_q[$past(upd_sector)] == $past(upd_data[BIT_LD])));

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sticky
    // R3: lock-down freezes both bits
    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
      ld_q[s] |=> (ld_q[s] && $stable(wl_q[s])));
  end
endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl #(
  parameter int SEC_W = 8,
  parameter int NUM_SECTORS = 1 << SEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sck,
  input  logic             spi_csn,
  input  logic             spi_mosi,
  input  logic             busy_i,
  input  logic             pe_req,
  input  logic [SEC_W-1:0] pe_sector,
  output logic             pe_grant,
  output logic             pe_block,
  output logic             wel_o
);
  logic             sck_rise, cs_rise, cs_active, data_bit;
  logic             wren_pulse, wrlr_pulse;
  logic [SEC_W-1:0] wrlr_sector;
  logic [7:0]       wrlr_data;
  logic             wel_q;
  logic             wrlr_ok;

  spi_pin_sync u_sync (
    .clk(clk), .rst(rst), .sck_in(spi_sck), .csn_in(spi_csn), .mosi_in(spi_mosi),
    .sck_rise(sck_rise), .cs_rise(cs_rise), .cs_active(cs_active), .data_bit(data_bit)
  );

  lock_cmd_decoder #(.SEC_W(SEC_W)) u_dec (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .cs_rise(cs_rise),
    .cs_active(cs_active), .data_bit(data_bit), .wren_pulse(wren_pulse),
    .wrlr_pulse(wrlr_pulse), .wrlr_sector(wrlr_sector), .wrlr_data(wrlr_data)
  );

  assign wrlr_ok = wrlr_pulse & wel_q & ~busy_i;

  always_ff @(posedge clk) begin
    if (rst)             wel_q <= 1'b0;
    else if (wren_pulse) wel_q <= 1'b1;
    else if (wrlr_ok)    wel_q <= 1'b0;
  end
  assign wel_o = wel_q;

  lock_reg_file #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_regs (
    .clk(clk), .rst(rst), .upd_en(wrlr_ok), .upd_sector(wrlr_sector),
    .upd_data(wrlr_data), .pe_req(pe_req), .pe_sector(pe_sector),
    .pe_grant(pe_grant), .pe_block(pe_block)
  );

  // R5: write enable arms the latch
  p_wren_sets_r5: assert property (@(posedge clk) disable iff (rst)
    wren_pulse |=> wel_q);
  // R8: executed lock write drops the latch
  p_wel_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wrlr_pulse && wel_q && !busy_i) |=> !wel_q);
  // R9: busy rejection keeps the latch
  p_busy_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (wrlr_pulse && busy_i && !wren_pulse) |=> $stable(wel_q));
endmodule

// File: tb/sector_lock_ctrl_test.sv
`timescale 1ns/1ps
module sector_lock_ctrl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic pe_req = 1'b0;
  logic [7:0] pe_sector = '0;
  logic pe_grant, pe_block, wel;
  int checks = 0, failures = 0;
  bit exp_wl[256];
  bit exp_ld[256];
  bit exp_wel;

  always #4 clk = ~clk;

  sector_lock_ctrl uut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .busy_i(busy), .pe_req(pe_req), .pe_sector(pe_sector),
    .pe_grant(pe_grant), .pe_block(pe_block), .wel_o(wel)
  );

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Send the first nbits of {op, addr, data}, MSB first, then raise CS
  task automatic send(logic [7:0] op, logic [23:0] addr, logic [7:0] data,
                      int nbits, bit bsy);
    logic [40:0] fr;
    fr = {op, addr, data, 1'b0};
    busy = bsy;
    @(negedge clk); csn = 1'b0; waitc(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = fr[40 - i]; waitc(4);
      sck = 1'b1; waitc(4);
      sck = 1'b0;
    end
    waitc(4); csn = 1'b1; waitc(10);
    busy = 1'b0;
    model(op, addr, data, nbits, bsy);
  endtask

  function automatic void model(logic [7:0] op, logic [23:0] addr, logic [7:0] data,
                                int nbits, bit bsy);
    int s = addr[23:16];
    if (nbits == 8 && op == 8'h06) exp_wel = 1'b1;
    else if (nbits == 40 && op == 8'hE5 && exp_wel && !bsy) begin
      if (!exp_ld[s]) begin exp_wl[s] = data[0]; exp_ld[s] = data[1]; end
      exp_wel = 1'b0;
    end
  endfunction

  task automatic probe(string req, int s);
    pe_sector = 8'(s); pe_req = 1'b1;
    @(negedge clk);
    check(req, {pe_grant, pe_block}, exp_wl[s] ? 2'b01 : 2'b10);
    pe_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_wel(string req);
    check(req, {1'b0, wel}, {1'b0, exp_wel});
  endtask

  initial begin
    void'($urandom(32'd2024));
    #1_600_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitc(5); rst = 1'b0; waitc(3);
    // R11 reset state
    chk_wel("R11");
    probe("R11", 0); probe("R11", 255);
    // R5 lock write without enable
    send(8'hE5, 24'h030000, 8'h01, 40, 0); probe("R5", 3);
    send(8'h06, 24'h0, 8'h0, 8, 0); chk_wel("R5");
    // R6 R2: lock sector 3 with low address bits nonzero
    send(8'hE5, 24'h03ABCD, 8'h01, 40, 0); probe("R6", 3); probe("R2", 4);
    chk_wel("R8");
    // R1 reserved bits only -> unlocks sector 3 (LD=0)
    send(8'h06, 24'h0, 8'h0, 8, 0);
    send(8'hE5, 24'h030000, 8'hFC, 40, 0); probe("R1", 3);
    // R4 set then clear
    send(8'h06, 24'h0, 8'h0, 8, 0);
    send(8'hE5, 24'h070000, 8'h01, 40, 0); probe("R4", 7);
    send(8'h06, 24'h0, 8'h0, 8, 0);
    send(8'hE5, 24'h070000, 8'h00, 40, 0); probe("R4", 7);
    // R3 lock-down then attempt clear; R8 WEL still clears
    send(8'h06, 24'h0, 8'h0, 8, 0);
    send(8'hE5, 24'hFF0000, 8'h03, 40, 0); probe("R3", 255);
    send(8'h06, 24'h0, 8'h0, 8, 0);
    send(8'hE5, 24'hFF1234, 8'h00, 40, 0); probe("R3", 255); chk_wel("R8");
    // R7 39 and 41 bits
    send(8'h06, 24'h0, 8'h0, 8, 0);
    send(8'hE5, 24'h090000, 8'h01, 39, 0); probe("R7", 9); chk_wel("R7");
    send(8'hE5, 24'h090000, 8'h01, 41, 0); probe("R7", 9); chk_wel("R7");
    send(8'h06, 24'h0, 8'h0, 9, 0);
    // R9 busy rejection
    send(8'hE5, 24'h0A0000, 8'h01, 40, 1); probe("R9", 10); chk_wel("R9");
    // R10 foreign opcode
    send(8'h9F, 24'h0A0000, 8'h01, 40, 0); probe("R10", 10); chk_wel("R10");
    send(8'hE5, 24'h0A0000, 8'h01, 40, 0); probe("R7", 10); chk_wel("R8");
    // random mix
    for (int it = 0; it < 120; it++) begin
      int k = $urandom_range(0, 9);
      int s = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 5);
      logic [7:0] d = 8'($urandom());
      bit b = ($urandom_range(0, 9) == 0);
      if (k < 3)       send(8'h06, 24'h0, 8'h0, 8, 0);
      else if (k < 7)  send(8'hE5, {8'(s), 16'($urandom())}, d, 40, b);
      else if (k < 8)  send(8'hE5, {8'(s), 16'h0}, d, $urandom_range(1, 45), b);
      else if (k < 9)  send(8'h06, 24'h0, 8'h0, $urandom_range(9, 12), 0);
      else             send(8'h5A, {8'(s), 16'h0}, d, 40, 0);
      chk_wel("R5");
      probe("R4", s);
      probe("R2", $urandom_range(0, 255));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule